// File: doc/BRIEF.md
# Multi-Phase Stage Clock Sequencer

This block splits every period of a slow I/O clock into a train of narrow, non-overlapping access windows for a chain of memory-based logic stages that work as a data path. The block runs on a fast clock whose frequency is a whole multiple of the I/O clock. It watches the I/O clock in the fast domain and starts a fresh phase train at each rising I/O edge. Phase k opens the access window of stage k. After the last stage's phase, one further fast cycle stays idle. That spare slot gives the I/O registers setup and hold margin against the first and last stages.

The same stages can be arranged as one long chain, two parallel chains or four parallel chains. A mode input picks the chain length L: the full stage count, half of it, or a quarter of it. The fast clock then needs L+1 cycles per I/O period. With eight stages this gives the 8-of-9, 4-of-5 and 2-of-3 schedules. When chains run in parallel, one phase index opens the same-position stage of every chain at once.

Top module: `stph_sequencer`

## Requirements
- R1: While reset is asserted, every `phase_o` and `stage_en_o` bit is low, and this takes effect at once, without waiting for a clock edge. After release, all outputs stay low until the first rising edge of `io_clk_i` is detected.
- R2: Call A the first fast edge that samples `io_clk_i` high after it was sampled low. `phase_o[0]` rises on the fast edge after A, so it is high during the second fast cycle after the edge is sampled.
- R3: With no new I/O edge, the high bit moves from `phase_o[k]` to `phase_o[k+1]` on each fast cycle up to `phase_o[L-1]`. The following cycle has all phase bits low (the spare slot).
- R4: The `mode_i` encoding sets the chain length L. 2'b00 gives L = MAX_STAGES, 2'b01 gives MAX_STAGES/2, 2'b10 gives MAX_STAGES/4, and 2'b11 behaves like 2'b00.
- R5: `mode_i` is captured only on the fast edge that starts a phase train (the edge that raises `phase_o[0]`). Changes at any other time take effect at the next train.
- R6: At most one bit of `phase_o` is high in any fast cycle.
- R7: `stage_en_o[s]` is high exactly when `phase_o[s mod L]` is high. So in the parallel-chain modes one phase drives the same position in every chain.
- R8: An I/O rising edge detected in the middle of a train restarts it. Phase 0 follows on the next edge, as set by R2, whatever phase was active.
- R9: If no further I/O edge arrives, the sequencer stays idle with all outputs low for as long as needed.
- R10: A `phase_o` bit whose index is L or higher is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock, (L+1) times the I/O clock frequency |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_clk_i | input | 1 | I/O clock, sampled in the fast domain |
| mode_i | input | 2 | Chain arrangement: 00 one chain, 01 two chains, 10 four chains, 11 as 00 |
| phase_o | output | MAX_STAGES | One-hot phase index within the current train |
| stage_en_o | output | MAX_STAGES | Per-stage access-window enable |

## Verification
The bound checker looks at every fast cycle for the following:
- the one-hot property of the phases, and that no phase bit at or above L is ever high;
- the step from one phase to the next and the spare slot after the last one;
- the quiet idle state when no I/O edge arrives;
- the restart to phase 0 after a detected edge;
- the length captured from the mode;
- the mapping from phases to stage enables.

Other behaviour can only be shown by the bench's scenarios:
- the exact latency from an `io_clk_i` transition at the pin to phase 0;
- outputs being cleared at once by an asynchronous reset in the middle of a train;
- the captured mode holding steady while `mode_i` changes inside a train.

The bench sweeps every mode against I/O periods of 2 to 12 fast cycles. That covers periods that are exactly matched, longer (extra idle) and shorter (resynchronisation) than the schedule.

// File: rtl/stph_pkg.sv
package stph_pkg;

  // Chain arrangement selected by the mode input.
  typedef enum logic [1:0] {
    SEQ_ONE_CHAIN   = 2'b00,
    SEQ_TWO_CHAINS  = 2'b01,
    SEQ_FOUR_CHAINS = 2'b10,
    SEQ_ONE_ALT     = 2'b11
  } seq_mode_e;

  // Stages per chain for a given mode.
  function automatic int unsigned stages_per_chain(input logic [1:0] mode,
                                                   input int unsigned max_stages);
    case (seq_mode_e'(mode))
      SEQ_TWO_CHAINS:  return max_stages >> 1;
      SEQ_FOUR_CHAINS: return max_stages >> 2;
      default:         return max_stages;
    endcase
  endfunction

endpackage

// File: rtl/stph_rst_sync.sv
// Reset synchroniser: asserts asynchronously, releases on the fast clock.
module stph_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/stph_io_edge.sv
// Samples the I/O clock in the fast domain and flags its rising edge.
module stph_io_edge #(
  parameter int unsigned SYNC_DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_clk_i,
  output logic rise_o
);

  logic [SYNC_DEPTH:0] samp_q;
  logic [SYNC_DEPTH:0] samp_d;

  always_comb begin
    samp_d = {samp_q[SYNC_DEPTH-1:0], io_clk_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
    end else begin
      samp_q <= samp_d;
    end
  end

  assign rise_o = samp_q[SYNC_DEPTH-1] & ~samp_q[SYNC_DEPTH];

endmodule

// File: rtl/stph_phase_counter.sv
// Phase index counter. It restarts on each detected I/O edge and parks in
// the spare slot (index == chain length) until the next edge.
module stph_phase_counter
  import stph_pkg::*;
#(
  parameter int unsigned MAX_STAGES = 8,
  parameter int unsigned CW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [1:0]    mode_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic [CW-1:0] len_nxt_o,
  output logic [CW-1:0] len_q_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic          adv_en;

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    adv_en = 1'b0;
    if (rise_i) begin
      adv_en = 1'b1;
      cnt_d  = '0;
      len_d  = CW'(stages_per_chain(mode_i, MAX_STAGES));
    end else if (cnt_q < len_q) begin
      adv_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(MAX_STAGES);
      len_q <= CW'(MAX_STAGES);
    end else if (adv_en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign len_nxt_o = len_d;
  assign len_q_o   = len_q;

endmodule

// File: rtl/stph_phase_decode.sv
// Registered one-hot decode of the next phase index and the per-stage map.
module stph_phase_decode #(
  parameter int unsigned MAX_STAGES = 8,
  parameter int unsigned CW         = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CW-1:0]         cnt_nxt_i,
  input  logic [CW-1:0]         len_nxt_i,
  output logic [MAX_STAGES-1:0] phase_o,
  output logic [MAX_STAGES-1:0] stage_en_o
);

  logic [MAX_STAGES-1:0] phase_d, phase_q;
  logic [MAX_STAGES-1:0] stage_d, stage_q;
  logic                  active;
  logic [CW-1:0]         pos_mask;

  always_comb begin
    active   = (cnt_nxt_i < len_nxt_i);
    pos_mask = len_nxt_i - CW'(1);
  end

  for (genvar k = 0; k < MAX_STAGES; k++) begin : g_slot
    localparam logic [CW-1:0] SLOT = CW'(k);
    assign phase_d[k] = active && (cnt_nxt_i == SLOT);
    assign stage_d[k] = active && (cnt_nxt_i == (SLOT & pos_mask));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      stage_q <= '0;
    end else begin
      phase_q <= phase_d;
      stage_q <= stage_d;
    end
  end

  assign phase_o    = phase_q;
  assign stage_en_o = stage_q;

endmodule

// File: rtl/stph_sequencer.sv
// Top: multi-phase stage clock sequencer.
module stph_sequencer #(
  parameter int unsigned MAX_STAGES = 8,
  parameter int unsigned RST_STAGES = 2,
  parameter int unsigned SYNC_DEPTH = 1
) (
  input  logic                  clk_fast_i,
  input  logic                  rst_ni,
  input  logic                  io_clk_i,
  input  logic [1:0]            mode_i,
  output logic [MAX_STAGES-1:0] phase_o,
  output logic [MAX_STAGES-1:0] stage_en_o
);

  localparam int unsigned CW = $clog2(MAX_STAGES + 1);

  logic          rst_s;
  logic          io_rise;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] len_nxt;
  logic [CW-1:0] len_q;

  stph_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  stph_io_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_io_edge (
    .clk_i    (clk_fast_i),
    .rst_ni   (rst_s),
    .io_clk_i (io_clk_i),
    .rise_o   (io_rise)
  );

  stph_phase_counter #(.MAX_STAGES(MAX_STAGES), .CW(CW)) u_counter (
    .clk_i     (clk_fast_i),
    .rst_ni    (rst_s),
    .rise_i    (io_rise),
    .mode_i    (mode_i),
    .cnt_nxt_o (cnt_nxt),
    .len_nxt_o (len_nxt),
    .len_q_o   (len_q)
  );

  stph_phase_decode #(.MAX_STAGES(MAX_STAGES), .CW(CW)) u_decode (
    .clk_i      (clk_fast_i),
    .rst_ni     (rst_s),
    .cnt_nxt_i  (cnt_nxt),
    .len_nxt_i  (len_nxt),
    .phase_o    (phase_o),
    .stage_en_o (stage_en_o)
  );

endmodule

// File: rtl/stph_checker.sv
// Cycle-level properties of the sequencer, bound to the top module.
module stph_checker
  import stph_pkg::*;
#(
  parameter int unsigned MAX_STAGES = 8,
  parameter int unsigned CW         = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  io_rise_i,
  input logic [1:0]            mode_i,
  input logic [CW-1:0]         len_q_i,
  input logic [MAX_STAGES-1:0] phase_i,
  input logic [MAX_STAGES-1:0] stage_en_i
);

  logic [MAX_STAGES-1:0] map_exp;
  logic [MAX_STAGES-1:0] beyond;
  logic [CW-1:0]         last_idx;

  always_comb begin
    last_idx = len_q_i - CW'(1);
    for (int s = 0; s < MAX_STAGES; s++) begin
      map_exp[s] = phase_i[int'(CW'(s) & last_idx)];
      beyond[s]  = phase_i[s] && (CW'(s) >= len_q_i);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_i == '0 && stage_en_i == '0));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rise_i |=> phase_i[0]);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rise_i && phase_i != '0 && !phase_i[last_idx])
      |=> phase_i == ($past(phase_i) << 1));

  p_spare_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rise_i && phase_i[last_idx]) |=> phase_i == '0);

  // R4 length encoding, captured at the train start as R5 requires
  p_mode_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rise_i |=> len_q_i == CW'(stages_per_chain($past(mode_i), MAX_STAGES)));

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_i));

  p_stage_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en_i == map_exp);

  p_resync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rise_i && phase_i != '0) |=> phase_i == MAX_STAGES'(1));

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rise_i && phase_i == '0) |=> phase_i == '0);

  p_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beyond == '0);

endmodule

bind stph_sequencer stph_checker #(.MAX_STAGES(MAX_STAGES), .CW(CW)) u_stph_checker (
  .clk_i      (clk_fast_i),
  .rst_ni     (rst_s),
  .io_rise_i  (io_rise),
  .mode_i     (mode_i),
  .len_q_i    (len_q),
  .phase_i    (phase_o),
  .stage_en_i (stage_en_o)
);

// File: tb/test_stph_sequencer.sv
`timescale 1ns/1ps
module test_stph_sequencer;

  localparam int MAXS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            io_clk;
  logic [1:0]      mode;
  logic [MAXS-1:0] phase;
  logic [MAXS-1:0] stage;

  stph_sequencer #(.MAX_STAGES(MAXS)) i_stph_sequencer (
    .clk_fast_i (clk),
    .rst_ni     (rst_n),
    .io_clk_i   (io_clk),
    .mode_i     (mode),
    .phase_o    (phase),
    .stage_en_o (stage)
  );

  int vectors     = 0;
  int miscompares = 0;
  int n      = 0;
  int r_cur  = 0;
  int r_prev = 0;
  int l_cur  = MAXS;
  int l_prev = MAXS;
  int pos    = 0;
  bit have_cur  = 0;
  bit have_prev = 0;
  bit io_prev   = 0;
  bit done      = 0;

  // R4: 00 -> 8, 01 -> 4, 10 -> 2, 11 -> 8 for eight stages
  function automatic int len_of(input logic [1:0] m);
    case (m)
      2'b01:   return MAXS / 2;
      2'b10:   return MAXS / 4;
      default: return MAXS;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [MAXS-1:0] ep,
                         input logic [MAXS-1:0] es);
    vectors++;
    if (phase !== ep || stage !== es) begin
      miscompares++;
      $display("FAIL %s tick %0d: phase=%b expected %b, stage_en=%b expected %b",
               tag, n, phase, ep, stage, es);
    end
  endtask

  task automatic clear_model();
    have_cur  = 0;
    have_prev = 0;
    io_prev   = 0;
    io_clk    = 1'b0;
    pos       = 0;
  endtask

  // One fast cycle: check at the falling edge, then drive the next inputs.
  task automatic tick(input string tag, input int period, input bit drive,
                      input logic [1:0] m);
    logic [MAXS-1:0] ep, es;
    int  r, l, d;
    bit  use_it;
    bit  io;
    @(negedge clk);
    n++;
    ep = '0;
    es = '0;
    use_it = 0;
    r = 0;
    l = MAXS;
    if (have_cur && (n - r_cur) >= 2) begin
      use_it = 1; r = r_cur; l = l_cur;
    end else if (have_prev) begin
      use_it = 1; r = r_prev; l = l_prev;
    end
    if (use_it) begin
      d = n - r - 2;
      if (d >= 0 && d < l) begin
        ep[d] = 1'b1;
        for (int s = 0; s < MAXS; s++) es[s] = ((s % l) == d);
      end
    end
    compare(tag, ep, es);
    mode = m;
    if (drive) begin
      io  = (pos < period / 2);
      pos = (pos + 1) % period;
    end else begin
      io = 1'b0;
    end
    if (io && !io_prev) begin
      r_prev    = r_cur;
      l_prev    = l_cur;
      have_prev = have_cur;
      r_cur     = n;
      have_cur  = 1;
    end
    io_prev = io;
    io_clk  = io;
    if (have_cur && n == r_cur + 1) l_cur = len_of(m);
  endtask

  task automatic apply_reset(input string tag);
    rst_n = 1'b0;
    #1;
    clear_model();
    compare(tag, '0, '0);
    repeat (3) tick(tag, 9, 0, 2'b00);
    rst_n = 1'b1;
    repeat (5) tick(tag, 9, 0, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b1;
    io_clk = 1'b0;
    mode   = 2'b00;
    #1;
    // R1: reset clears outputs and they stay low until the first I/O edge
    apply_reset("R1");

    // R2 R3 R6: basic 8-of-9 schedule
    pos = 0;
    repeat (40) tick("R2 R3 R6", 9, 1, 2'b00);

    // R4 R7 R10 R3: every mode against I/O periods of 2..12 fast cycles
    for (int m = 0; m < 4; m++) begin
      for (int p = 2; p <= 12; p++) begin
        pos = 0;
        repeat (4 * p + MAXS) tick("R4 R7 R10", p, 1, 2'(m));
      end
    end

    // R9: I/O clock stops; sequencer idles
    repeat (25) tick("R9", 9, 0, 2'b00);

    // R5: mode changes every cycle inside trains
    pos = 0;
    for (int i = 0; i < 90; i++) tick("R5", 9, 1, 2'(i % 3));

    // R8: I/O period shorter than the schedule forces restarts
    pos = 0;
    repeat (48) tick("R8", 6, 1, 2'b00);
    pos = 0;
    repeat (30) tick("R8", 4, 1, 2'b01);

    // R1: reset asserted in the middle of a train
    pos = 0;
    repeat (5) tick("R1", 9, 1, 2'b00);
    apply_reset("R1");
    pos = 0;
    repeat (30) tick("R1 R2", 9, 1, 2'b00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule